// File: doc/BRIEF.md
# SDRAM Special-Mode Command Translator

This block sits between a simple single-outstanding memory-mapped bus and a DDR2 command port. A control word sets the translator's behaviour: an enable bit, a 3-bit operating-mode field, and the row, column and data-size geometry codes. When the translator is enabled and the mode is one of the special modes, a bus write into the SDRAM window does not move data. It is turned into exactly one DDR2 command, and the write address supplies the command's bank and address-line contents. In normal mode, window accesses go straight through to a data-path stub.

Software brings the memory up by first selecting a mode and then issuing plain writes. A write with address bit 10 set in precharge mode closes every bank. Any write in a refresh mode issues one refresh. In load-mode-register mode, address bits 26:25 pick the mode register (01 = EMR1, 10 = EMR2, 11 = EMR3) and address bits 13:0 carry its contents, so offset 0x0200_0400 loads EMR1 with 0x400.

A four-state machine drives each command. From S_IDLE, an accepted command write moves to S_ISSUE. S_ISSUE goes to S_ACK if cmd_ready is high, and to S_HOLD if it is low. S_HOLD stays put until cmd_ready rises, then moves to S_ACK. S_ACK always returns to S_IDLE. Control-word accesses, window reads in special modes, and writes that are dropped all go from S_IDLE directly to S_ACK. Normal-mode forwarding keeps the machine in S_IDLE.

Top module: `sdcmd_xlate`

## Requirements
- R1: While reset is asserted, cmd_valid and bus_ack are low, and after reset the control word reads back as 0.
- R2: A control-word write (bus_csr_sel=1) stores enable at bit 31, mode at 30:28, row code at 25:24, column code at 21:20 and data-size code at 17:16; every other bit reads as 0; the access is acknowledged one cycle after it is presented.
- R3: A control-word write whose column code (bits 21:20) equals 3 is ignored entirely, and the previous word reads back unchanged.
- R4: While enable is 0, a window write is acknowledged in one cycle, raises neither cmd_valid nor dp_req, and issues no command.
- R5: In mode 1 (precharge), a window write issues cmd_op=1 (precharge all) when address bit 10 is set. Otherwise it issues cmd_op=0 (single-bank precharge) with cmd_bank = address bits 26:25. In both cases cmd_addr = address bits 13:0.
- R6: In mode 2 (auto-refresh) and mode 4 (manual refresh), any window write issues cmd_op=2 with cmd_bank=0 and cmd_addr=0, whatever its address.
- R7: In mode 3 (load mode register), a window write issues cmd_op=3 with cmd_bank = address bits 26:25 and cmd_addr = address bits 13:0. Address bits 24:14 have no effect.
- R8: Each translated command raises cmd_valid for exactly one cycle.
- R9: bus_ack for a translated command rises in the cycle after the one in which cmd_ready is sampled high, and not before.
- R10: With enable set and mode 0, a window access drives dp_req, dp_we, dp_addr and dp_wdata from the bus unchanged in the same cycle, and bus_ack and bus_rdata follow dp_ack and dp_rdata.
- R11: Window writes in modes 5–7, and window reads in any special mode, are acknowledged in one cycle and issue no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request, held until bus_ack |
| bus_csr_sel | input | 1 | 1 selects the control word, 0 the SDRAM window |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the SDRAM window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (control word or data-path data) |
| bus_ack | output | 1 | Access completion |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_ready | input | 1 | Command port has taken the command |
| cmd_op | output | 2 | 0 bank precharge, 1 precharge all, 2 refresh, 3 load mode register |
| cmd_bank | output | 2 | Bank or mode-register select |
| cmd_addr | output | MA_W | DRAM address lines |
| dp_req | output | 1 | Forwarded request to the data-path stub |
| dp_we | output | 1 | Forwarded write enable |
| dp_addr | output | ADDR_W | Forwarded address |
| dp_wdata | output | DATA_W | Forwarded write data |
| dp_rdata | input | DATA_W | Data-path read data |
| dp_ack | input | 1 | Data-path completion |

## Verification
The properties rely on a bus master that keeps at most one access outstanding. That master holds bus_req and its qualifiers steady until it sees bus_ack, and drops the request in the cycle that acknowledge appears, so the control word cannot change while a command is in flight. They also rely on cmd_ready being driven only in response to a pending command. The stimulus runs one transfer at a time through a single task that releases the request on the acknowledge. It raises cmd_ready a chosen number of cycles after cmd_valid is seen and lowers it one cycle later.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // operating-mode field values
    localparam logic [2:0] MODE_NORMAL    = 3'd0;
    localparam logic [2:0] MODE_PRECHARGE = 3'd1;
    localparam logic [2:0] MODE_AUTOREF   = 3'd2;
    localparam logic [2:0] MODE_LOADMR    = 3'd3;
    localparam logic [2:0] MODE_MANREF    = 3'd4;

    // control word bit positions
    localparam int EN_BIT   = 31;
    localparam int MODE_LSB = 28;
    localparam int ROW_LSB  = 24;
    localparam int COL_LSB  = 20;
    localparam int DSZ_LSB  = 16;
    localparam logic [1:0] COL_MAX_CODE = 2'd2;

    typedef enum logic [1:0] {
        OP_PRE_BANK = 2'd0,
        OP_PRE_ALL  = 2'd1,
        OP_REFRESH  = 2'd2,
        OP_LOAD_MR  = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        ACC_FWD  = 2'd0,
        ACC_CMD  = 2'd1,
        ACC_DROP = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_HOLD  = 2'd2,
        S_ACK   = 2'd3
    } xl_state_e;

endpackage

// File: rtl/sdcmd_ctl_reg.sv
module sdcmd_ctl_reg
    import sdcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_enable_bit,
    input  logic [2:0]  wr_mode,
    input  logic [1:0]  wr_row,
    input  logic [1:0]  wr_col,
    input  logic [1:0]  wr_dsz,
    output logic        ctl_en,
    output logic [2:0]  ctl_mode,
    output logic [31:0] ctl_word
);

    logic [1:0] row_q;
    logic [1:0] col_q;
    logic [1:0] dsz_q;
    logic       accept;

    // a column code beyond the legal range rejects the whole word
    assign accept = wr_en && (wr_col <= COL_MAX_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_mode <= MODE_NORMAL;
            row_q    <= '0;
            col_q    <= '0;
            dsz_q    <= '0;
        end else if (accept) begin
            ctl_en   <= wr_enable_bit;
            ctl_mode <= wr_mode;
            row_q    <= wr_row;
            col_q    <= wr_col;
            dsz_q    <= wr_dsz;
        end
    end

    always_comb begin
        ctl_word = '0;
        ctl_word[EN_BIT]                 = ctl_en;
        ctl_word[MODE_LSB +: 3]          = ctl_mode;
        ctl_word[ROW_LSB +: 2]           = row_q;
        ctl_word[COL_LSB +: 2]           = col_q;
        ctl_word[DSZ_LSB +: 2]           = dsz_q;
    end

endmodule

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
#(
    parameter int MA_W     = 14,
    parameter int PALL_BIT = 10
) (
    input  logic            en,
    input  logic [2:0]      mode,
    input  logic            we,
    input  logic [1:0]      bank_bits,
    input  logic [MA_W-1:0] low_bits,
    output acc_kind_e       kind,
    output cmd_op_e         op,
    output logic [1:0]      bank,
    output logic [MA_W-1:0] maddr
);

    always_comb begin
        kind  = ACC_DROP;
        op    = OP_REFRESH;
        bank  = '0;
        maddr = '0;
        if (en) begin
            unique case (mode)
                MODE_NORMAL: begin
                    kind = ACC_FWD;
                end
                MODE_PRECHARGE: begin
                    if (we) begin
                        kind  = ACC_CMD;
                        op    = low_bits[PALL_BIT] ? OP_PRE_ALL : OP_PRE_BANK;
                        bank  = bank_bits;
                        maddr = low_bits;
                    end
                end
                MODE_AUTOREF, MODE_MANREF: begin
                    if (we) begin
                        kind = ACC_CMD;
                        op   = OP_REFRESH;
                    end
                end
                MODE_LOADMR: begin
                    if (we) begin
                        kind  = ACC_CMD;
                        op    = OP_LOAD_MR;
                        bank  = bank_bits;
                        maddr = low_bits;
                    end
                end
                default: begin
                    kind = ACC_DROP;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_fsm.sv
module sdcmd_fsm
    import sdcmd_pkg::*;
#(
    parameter int MA_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            csr_sel,
    input  logic            we,
    input  acc_kind_e       kind,
    input  cmd_op_e         op_in,
    input  logic [1:0]      bank_in,
    input  logic [MA_W-1:0] maddr_in,
    input  logic            cmd_ready,
    output logic            cmd_valid,
    output cmd_op_e         cmd_op,
    output logic [1:0]      cmd_bank,
    output logic [MA_W-1:0] cmd_addr,
    output logic            ack,
    output logic            idle,
    output logic            csr_wr
);

    xl_state_e state_q;
    xl_state_e state_d;
    logic      take_cmd;

    assign take_cmd = (state_q == S_IDLE) && req && !csr_sel && (kind == ACC_CMD);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req) begin
                    if (csr_sel) begin
                        state_d = S_ACK;
                    end else begin
                        unique case (kind)
                            ACC_CMD:  state_d = S_ISSUE;
                            ACC_DROP: state_d = S_ACK;
                            default:  state_d = S_IDLE;
                        endcase
                    end
                end
            end
            S_ISSUE: state_d = cmd_ready ? S_ACK : S_HOLD;
            S_HOLD:  state_d = cmd_ready ? S_ACK : S_HOLD;
            S_ACK:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_op   <= OP_PRE_BANK;
            cmd_bank <= '0;
            cmd_addr <= '0;
        end else if (take_cmd) begin
            cmd_op   <= op_in;
            cmd_bank <= bank_in;
            cmd_addr <= maddr_in;
        end
    end

    // outputs
    always_comb begin
        cmd_valid = (state_q == S_ISSUE);
        ack       = (state_q == S_ACK);
        idle      = (state_q == S_IDLE);
        csr_wr    = (state_q == S_IDLE) && req && csr_sel && we;
    end

endmodule

// File: rtl/sdcmd_xlate.sv
module sdcmd_xlate
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int MA_W     = 14,
    parameter int BANK_LSB = 25,
    parameter int PALL_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_csr_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [1:0]        cmd_bank,
    output logic [MA_W-1:0]   cmd_addr,
    output logic              dp_req,
    output logic              dp_we,
    output logic [ADDR_W-1:0] dp_addr,
    output logic [DATA_W-1:0] dp_wdata,
    input  logic [DATA_W-1:0] dp_rdata,
    input  logic              dp_ack
);

    localparam int BA_W = 2;

    logic            ctl_en;
    logic [2:0]      ctl_mode;
    logic [31:0]     ctl_word;
    logic            csr_wr;
    logic            fsm_ack;
    logic            fsm_idle;
    acc_kind_e       dec_kind;
    cmd_op_e         dec_op;
    logic [BA_W-1:0] dec_bank;
    logic [MA_W-1:0] dec_maddr;
    cmd_op_e         fsm_op;

    sdcmd_ctl_reg u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (csr_wr),
        .wr_enable_bit (bus_wdata[EN_BIT]),
        .wr_mode       (bus_wdata[MODE_LSB +: 3]),
        .wr_row        (bus_wdata[ROW_LSB +: 2]),
        .wr_col        (bus_wdata[COL_LSB +: 2]),
        .wr_dsz        (bus_wdata[DSZ_LSB +: 2]),
        .ctl_en        (ctl_en),
        .ctl_mode      (ctl_mode),
        .ctl_word      (ctl_word)
    );

    sdcmd_decode #(
        .MA_W     (MA_W),
        .PALL_BIT (PALL_BIT)
    ) u_dec (
        .en        (ctl_en),
        .mode      (ctl_mode),
        .we        (bus_we),
        .bank_bits (bus_addr[BANK_LSB +: BA_W]),
        .low_bits  (bus_addr[MA_W-1:0]),
        .kind      (dec_kind),
        .op        (dec_op),
        .bank      (dec_bank),
        .maddr     (dec_maddr)
    );

    sdcmd_fsm #(
        .MA_W (MA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .csr_sel   (bus_csr_sel),
        .we        (bus_we),
        .kind      (dec_kind),
        .op_in     (dec_op),
        .bank_in   (dec_bank),
        .maddr_in  (dec_maddr),
        .cmd_ready (cmd_ready),
        .cmd_valid (cmd_valid),
        .cmd_op    (fsm_op),
        .cmd_bank  (cmd_bank),
        .cmd_addr  (cmd_addr),
        .ack       (fsm_ack),
        .idle      (fsm_idle),
        .csr_wr    (csr_wr)
    );

    assign cmd_op    = fsm_op;

    // normal-mode pass-through
    assign dp_req    = bus_req && !bus_csr_sel && fsm_idle && (dec_kind == ACC_FWD);
    assign dp_we     = bus_we;
    assign dp_addr   = bus_addr;
    assign dp_wdata  = bus_wdata;

    assign bus_ack   = fsm_ack || (dp_req && dp_ack);
    assign bus_rdata = bus_csr_sel ? DATA_W'(ctl_word) : dp_rdata;

endmodule

// File: rtl/sdcmd_xlate_chk.sv
module sdcmd_xlate_chk
    import sdcmd_pkg::*;
#(
    parameter int MA_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [1:0]      cmd_op,
    input logic [1:0]      cmd_bank,
    input logic [MA_W-1:0] cmd_addr,
    input logic            bus_ack,
    input logic            dp_req,
    input logic            ctl_en,
    input logic [2:0]      ctl_mode
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!cmd_valid && !bus_ack);
        end
    end

    assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> (!cmd_valid && !dp_req));

    assert_precharge_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_PRE_ALL || cmd_op == OP_PRE_BANK)) |-> (ctl_mode == MODE_PRECHARGE));

    assert_refresh_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_REFRESH) |-> (cmd_bank == 2'd0 && cmd_addr == '0));

    assert_loadmr_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_LOAD_MR) |-> (ctl_mode == MODE_LOADMR));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_ack_waits_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> !bus_ack);

    assert_forward_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req |-> (ctl_en && ctl_mode == MODE_NORMAL && !cmd_valid));

    assert_reserved_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode > MODE_MANREF) |-> (!cmd_valid && !dp_req));

endmodule

bind sdcmd_xlate sdcmd_xlate_chk #(.MA_W(MA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cmd_addr  (cmd_addr),
    .bus_ack   (bus_ack),
    .dp_req    (dp_req),
    .ctl_en    (ctl_en),
    .ctl_mode  (ctl_mode)
);

// File: tb/sdcmd_xlate_test.sv
module sdcmd_xlate_test;

    typedef struct {
        logic [1:0]  op;
        logic [1:0]  bank;
        logic [13:0] addr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_csr_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [1:0]  cmd_op;
    logic [1:0]  cmd_bank;
    logic [13:0] cmd_addr;
    logic        dp_req;
    logic        dp_we;
    logic [31:0] dp_addr;
    logic [31:0] dp_wdata;
    logic [31:0] dp_rdata = '0;
    logic        dp_ack = 1'b0;

    int   n_checks = 0;
    int   n_fail = 0;
    int   ready_lat = 0;
    int   rdy_wait = 0;
    bit   rdy_pending = 0;
    bit   prev_valid = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    sdcmd_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_csr_sel(bus_csr_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .dp_req(dp_req), .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
        .dp_rdata(dp_rdata), .dp_ack(dp_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input logic [2:0] mode);
        return {en, mode, 2'b00, 2'd2, 2'b00, 2'd1, 2'b00, 2'd2, 16'h0000};
    endfunction

    // monitor: pops expected commands, drives cmd_ready
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (cmd_ready) begin
                cmd_ready = 1'b0;
                rdy_pending = 0;
            end else if (cmd_valid) begin
                if (prev_valid) chk(0, "R8 valid longer than one cycle", 32'd1, 32'd0);
                if (exp_q.size() == 0) begin
                    chk(0, "R4/R11 unexpected command", {30'd0, cmd_op}, 32'hFFFF_FFFF);
                end else begin
                    e = exp_q.pop_front();
                    chk(cmd_op == e.op, "R5/R6/R7 cmd_op", {30'd0, cmd_op}, {30'd0, e.op});
                    chk(cmd_bank == e.bank, "R5/R6/R7 cmd_bank", {30'd0, cmd_bank}, {30'd0, e.bank});
                    chk(cmd_addr == e.addr, "R5/R6/R7 cmd_addr", {18'd0, cmd_addr}, {18'd0, e.addr});
                end
                rdy_pending = 1;
                rdy_wait = ready_lat;
            end else if (rdy_pending && rdy_wait > 0) begin
                rdy_wait--;
            end
            if (rdy_pending && rdy_wait == 0 && !cmd_valid && !cmd_ready && ready_lat > 0) begin
                cmd_ready = 1'b1;
            end else if (rdy_pending && cmd_valid && ready_lat == 0) begin
                cmd_ready = 1'b1;
            end
            prev_valid = cmd_valid;
        end
    end

    task automatic bus_xfer(input bit csr, input bit we, input logic [31:0] addr, input logic [31:0] data,
                            input int exp_cycles, input string req, output logic [31:0] rdata);
        int  cycles = 0;
        bit  saw_dp = 0;
        @(negedge clk);
        bus_req = 1'b1; bus_csr_sel = csr; bus_we = we; bus_addr = addr; bus_wdata = data;
        while (1) begin
            @(negedge clk);
            cycles++;
            if (dp_req) saw_dp = 1;
            if (bus_ack || cycles > 50) break;
        end
        rdata = bus_rdata;
        bus_req = 1'b0;
        chk(cycles == exp_cycles, {req, " ack latency"}, cycles, exp_cycles);
        chk(!saw_dp, {req, " no forwarding"}, {31'd0, saw_dp}, 32'd0);
    endtask

    task automatic set_ctl(input logic [31:0] word);
        logic [31:0] rd;
        bus_xfer(1, 1, '0, word, 1, "R2 write", rd);
    endtask

    task automatic read_ctl(input logic [31:0] exp, input string req);
        logic [31:0] rd;
        bus_xfer(1, 0, '0, '0, 1, req, rd);
        chk(rd == exp, {req, " readback"}, rd, exp);
    endtask

    task automatic issue(input logic [31:0] addr, input logic [1:0] op, input logic [1:0] bank,
                         input logic [13:0] maddr, input int lat, input string req);
        exp_t e;
        logic [31:0] rd;
        e.op = op; e.bank = bank; e.addr = maddr;
        exp_q.push_back(e);
        ready_lat = lat;
        bus_xfer(0, 1, addr, 32'h0000_00DA, 2 + lat, req, rd);
        chk(exp_q.size() == 0, {req, " command seen"}, exp_q.size(), 0);
    endtask

    task automatic silent(input bit we, input logic [31:0] addr, input string req);
        logic [31:0] rd;
        bus_xfer(0, we, addr, 32'h0000_00DA, 1, req, rd);
        @(negedge clk);
        chk(!cmd_valid && exp_q.size() == 0, {req, " no command"}, {31'd0, cmd_valid}, 32'd0);
    endtask

    task automatic fwd(input bit we, input logic [31:0] addr, input logic [31:0] data, input logic [31:0] rdv);
        @(negedge clk);
        bus_req = 1'b1; bus_csr_sel = 1'b0; bus_we = we; bus_addr = addr; bus_wdata = data;
        #2;
        chk(dp_req == 1'b1, "R10 dp_req", {31'd0, dp_req}, 32'd1);
        chk(dp_we == we, "R10 dp_we", {31'd0, dp_we}, {31'd0, we});
        chk(dp_addr == addr, "R10 dp_addr", dp_addr, addr);
        chk(dp_wdata == data, "R10 dp_wdata", dp_wdata, data);
        chk(bus_ack == 1'b0, "R10 ack before dp_ack", {31'd0, bus_ack}, 32'd0);
        dp_ack = 1'b1; dp_rdata = rdv;
        #2;
        chk(bus_ack == 1'b1, "R10 ack follows dp_ack", {31'd0, bus_ack}, 32'd1);
        chk(bus_rdata == rdv, "R10 rdata", bus_rdata, rdv);
        @(negedge clk);
        bus_req = 1'b0; dp_ack = 1'b0;
        chk(!cmd_valid, "R10 no command", {31'd0, cmd_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_valid == 1'b0, "R1 cmd_valid in reset", {31'd0, cmd_valid}, 32'd0);
        chk(bus_ack == 1'b0, "R1 bus_ack in reset", {31'd0, bus_ack}, 32'd0);
        rst_n = 1'b1;
        read_ctl(32'h0, "R1");

        // R2: field placement, stray bits dropped
        set_ctl(32'hFA2A_5A5A);
        read_ctl(32'hF222_0000, "R2");
        // R3: illegal column code ignored
        set_ctl(32'h8030_0000);
        read_ctl(32'hF222_0000, "R3");

        // R4: disabled
        set_ctl(mk(0, 3'd1));
        silent(1, 32'h0000_0400, "R4");
        set_ctl(mk(0, 3'd0));
        silent(1, 32'h0000_0010, "R4 normal");

        // R5: precharge
        set_ctl(mk(1, 3'd1));
        read_ctl(mk(1, 3'd1), "R2");
        issue(32'h0000_0400, 2'd1, 2'd0, 14'h0400, 0, "R5 all R9");
        issue(32'h0400_0000, 2'd0, 2'd2, 14'h0000, 3, "R5 bank R9");
        issue(32'h0600_0404, 2'd1, 2'd3, 14'h0404, 1, "R5 all bank3");
        silent(0, 32'h0000_0400, "R11 read precharge");

        // R6: refresh modes
        set_ctl(mk(1, 3'd2));
        issue(32'h0000_0000, 2'd2, 2'd0, 14'h0000, 0, "R6 autoref");
        issue(32'h0600_0123, 2'd2, 2'd0, 14'h0000, 2, "R6 autoref addr");
        set_ctl(mk(1, 3'd4));
        issue(32'h0200_0780, 2'd2, 2'd0, 14'h0000, 0, "R6 manual");

        // R7: load mode register
        set_ctl(mk(1, 3'd3));
        issue(32'h0400_0000, 2'd3, 2'd2, 14'h0000, 1, "R7 emr2");
        issue(32'h0600_0000, 2'd3, 2'd3, 14'h0000, 0, "R7 emr3");
        issue(32'h0200_0400, 2'd3, 2'd1, 14'h0400, 2, "R7 emr1 dll");
        issue(32'h0200_0780, 2'd3, 2'd1, 14'h0780, 0, "R7 ocd");
        issue(32'h0000_0333, 2'd3, 2'd0, 14'h0333, 0, "R7 mr");
        issue(32'h01FF_FFFF, 2'd3, 2'd0, 14'h3FFF, 4, "R7 bits 24:14");
        silent(0, 32'h0200_0400, "R11 read loadmr");

        // R11: reserved modes
        set_ctl(mk(1, 3'd5));
        silent(1, 32'h0000_0400, "R11 mode5");
        set_ctl(mk(1, 3'd7));
        silent(1, 32'h0600_0000, "R11 mode7");

        // R10: normal pass-through
        set_ctl(mk(1, 3'd0));
        fwd(1, 32'h1234_5678, 32'hCAFE_0001, 32'h0);
        fwd(0, 32'h0000_0ABC, 32'h0, 32'h5A5A_A5A5);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1..: run hung, actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule